// File: doc/BRIEF.md
# Synchronous Clock Gating Controller

This block sits between a set of free-running source clocks and the pins that carry them. It produces eighteen gated outputs: three in a host group, eight memory clocks, six peripheral-bus clocks and one graphics-port clock. Each output has its own enable bit in one of three 8-bit control registers. A global active-low power-down input can stop every output at once. The block is clocked by a fast system clock that samples each source clock as a level. Every gating decision is made only while the source is sampled low. As a result an output is either a full copy of a source high phase or stays low, and it never carries a shortened pulse.

The control registers are written and read through a plain select/data port on behalf of the serial control interface. While the block is not in normal running, that interface is disabled: writes are dropped and reads return zero. When power-down is requested, the block first parks every output low. Only then does it request shutdown of the PLLs and the oscillator. When power-down is released, it withdraws that request, holds all outputs low for a lock-wait interval and then lets them start again, each on its own next source high phase.

Top module: `clkgate_ctrl`

## Requirements
- R1: After reset, the registers read back 0x07 at select 0 (host group), 0xFF at select 1 (memory) and 0xFE at select 2 (peripheral), and every clock output is low.
- R2: Output mapping: clk_out[2:0] is enabled by select-0 bits 2:0, clk_out[10:3] by select-1 bits 7:0, and clk_out[17:11] by select-2 bits 7:1. With its bit at 1, an output copies its source. With its bit at 0, it stays low.
- R3: An output goes high only in a cycle where its source is high, and once high it stays high for the whole source high phase, so every output high pulse has the full source length.
- R4: An enable passes through a two-flop synchroniser and is applied only in a cycle where the source is sampled low. The output follows the source with one register of delay, so the output timing is exact to the cycle.
- R5: While pd_n is held low, the outputs are stopped after their current high phase. pll_off_req rises only after every output and every synchroniser stage is low, and no output is high while pll_off_req is high.
- R6: ser_en is high only during normal running. When ser_en is low, register writes are ignored and rd_data reads zero.
- R7: After pd_n returns high, pll_off_req falls and all outputs stay low for at least LOCK_CYCLES cycles. A low pd_n seen during the lock wait returns the block to shutdown.
- R8: Select-0 bits 7:3 and select-2 bit 0 are stored and read back as written, but have no effect on any output.
- R9: Register contents are kept through a full power-down and release.
- R10: Select 3 is unmapped: it reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request, asynchronous |
| src_in | input | 18 | Free-running source clock levels, one per output |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for the write |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register select for the read |
| rd_data | output | 8 | Read data (combinational) |
| clk_out | output | 18 | Gated clock outputs |
| ser_en | output | 1 | Serial control interface enabled |
| pll_off_req | output | 1 | Request to shut off the PLLs and oscillator |

## Verification
A register write and the sampling of a falling pd_n can occur in the same cycle. The write is then still accepted, because the sequencer leaves normal running only on the following edge. The bench provokes this by driving pd_n low and the write strobe on the same falling edge. It judges the outcome with its own model and by reading the register back after release. The bench also toggles enables rapidly against sources whose phases are unrelated to the writes, so that enable changes land in every source phase. Every completed output pulse is then measured against the known half period of its source.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  localparam int REG_W    = 8;
  localparam int N_HOST   = 3;
  localparam int N_MEM    = 8;
  localparam int N_PERIPH = 7;
  localparam int N_OUT    = N_HOST + N_MEM + N_PERIPH;
  localparam int N_REGS   = 3;

  localparam logic [REG_W-1:0] HOST_RST   = 8'h07;
  localparam logic [REG_W-1:0] MEM_RST    = 8'hFF;
  localparam logic [REG_W-1:0] PERIPH_RST = 8'hFE;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_OFF   = 2'd2,
    ST_LOCK  = 2'd3
  } pd_state_e;
endpackage

// File: rtl/clkgate_regs.sv
module clkgate_regs
  import clkgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_ok,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic [N_OUT-1:0] en_vec
);
  logic [REG_W-1:0] host_q, mem_q, periph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_q   <= HOST_RST;
      mem_q    <= MEM_RST;
      periph_q <= PERIPH_RST;
    end else if (wr_en && acc_ok) begin
      case (wr_sel)
        2'd0:    host_q   <= wr_data;
        2'd1:    mem_q    <= wr_data;
        2'd2:    periph_q <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (acc_ok) begin
      case (rd_sel)
        2'd0:    rd_data = host_q;
        2'd1:    rd_data = mem_q;
        2'd2:    rd_data = periph_q;
        default: rd_data = '0;
      endcase
    end
  end

  // reserved bits (host 7:3, periph 0) are dropped here
  assign en_vec = {periph_q[REG_W-1:1], mem_q, host_q[N_HOST-1:0]};
endmodule

// File: rtl/clkgate_seq.sv
module clkgate_seq
  import clkgate_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic all_parked,
  output logic allow,
  output logic pll_off_req,
  output logic ser_en
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic             pd_s1, pd_s2;
  pd_state_e        st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_s1 <= 1'b1;
      pd_s2 <= 1'b1;
      st    <= ST_RUN;
      cnt   <= '0;
    end else begin
      pd_s1 <= pd_n;
      pd_s2 <= pd_s1;
      case (st)
        ST_RUN:   if (!pd_s2) st <= ST_DRAIN;
        ST_DRAIN: if (all_parked) st <= ST_OFF;
        ST_OFF: begin
          if (pd_s2) begin
            st  <= ST_LOCK;
            cnt <= '0;
          end
        end
        ST_LOCK: begin
          if (!pd_s2) st <= ST_DRAIN;
          else if (cnt == CNT_W'(LOCK_CYCLES - 1)) st <= ST_RUN;
          else cnt <= cnt + 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign allow       = (st == ST_RUN);
  assign ser_en      = (st == ST_RUN);
  assign pll_off_req = (st == ST_OFF);
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic src,
  output logic clk_o,
  output logic parked
);
  logic s1, s2, gate_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1     <= 1'b0;
      s2     <= 1'b0;
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      s1    <= en;
      s2    <= s1;
      out_q <= src & gate_q;
      if (!src) gate_q <= s2;
    end
  end

  assign clk_o  = out_q;
  assign parked = !(s1 | s2 | gate_q | out_q);
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic [N_OUT-1:0] src_in,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic [N_OUT-1:0] clk_out,
  output logic             ser_en,
  output logic             pll_off_req
);
  logic [N_OUT-1:0] en_vec;
  logic [N_OUT-1:0] parked;
  logic             allow;

  clkgate_regs u_regs (
    .clk(clk), .rst_n(rst_n), .acc_ok(ser_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .en_vec(en_vec)
  );

  clkgate_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .all_parked(&parked),
    .allow(allow), .pll_off_req(pll_off_req), .ser_en(ser_en)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_cell
    clkgate_cell u_cell (
      .clk(clk), .rst_n(rst_n), .en(en_vec[i] & allow), .src(src_in[i]),
      .clk_o(clk_out[i]), .parked(parked[i])
    );
  end
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk
  import clkgate_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [N_OUT-1:0] src_in,
  input logic [N_OUT-1:0] clk_out,
  input logic             ser_en,
  input logic             pll_off_req
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_chk
    assert_out_needs_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clk_out[i] |-> $past(src_in[i]));
    assert_no_runt_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_out[i] && src_in[i]) |=> clk_out[i]);
  end

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off_req |-> (clk_out == '0));

  assert_off_no_serial_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_off_req |-> !ser_en);

  assert_release_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_off_req) |-> (clk_out == '0));
endmodule

bind clkgate_ctrl clkgate_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .clk_out(clk_out),
  .ser_en(ser_en), .pll_off_req(pll_off_req)
);

// File: tb/clkgate_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkgate_ctrl_tb_top;
  localparam int NO   = 18;
  localparam int LOCK = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pd_n = 1'b1;
  logic [NO-1:0] src_in = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  rd_sel = '0;
  logic [7:0]  rd_data;
  logic [NO-1:0] clk_out;
  logic        ser_en, pll_off_req;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  clkgate_ctrl #(.LOCK_CYCLES(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .src_in(src_in),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .clk_out(clk_out),
    .ser_en(ser_en), .pll_off_req(pll_off_req)
  );

  // ---------------- source generators ----------------
  int half [NO];
  int scnt [NO];
  initial for (int i = 0; i < NO; i++) begin
    half[i] = 2 + (i % 3);
    scnt[i] = i % half[i];
  end
  always @(negedge clk) for (int i = 0; i < NO; i++) begin
    scnt[i] = scnt[i] + 1;
    if (scnt[i] >= half[i]) begin
      scnt[i] = 0;
      src_in[i] = ~src_in[i];
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_reg [3];
  int m_st, m_cnt;
  bit m_pd1, m_pd2;
  bit m_s1 [NO], m_s2 [NO], m_g [NO], m_o [NO];

  function automatic bit en_bit(int i);
    if (i < 3)       return m_reg[0][i];
    else if (i < 11) return m_reg[1][i-3];
    else             return m_reg[2][i-10];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg[0] = 'h07; m_reg[1] = 'hFF; m_reg[2] = 'hFE;
      m_st = 0; m_cnt = 0; m_pd1 = 1; m_pd2 = 1;
      for (int i = 0; i < NO; i++) begin
        m_s1[i] = 0; m_s2[i] = 0; m_g[i] = 0; m_o[i] = 0;
      end
    end else begin
      bit run, quiet, e;
      run = (m_st == 0);
      quiet = 1;
      for (int i = 0; i < NO; i++)
        if (m_s1[i] || m_s2[i] || m_g[i] || m_o[i]) quiet = 0;
      for (int i = 0; i < NO; i++) begin
        e = en_bit(i) && run;
        m_o[i] = src_in[i] && m_g[i];
        if (!src_in[i]) m_g[i] = m_s2[i];
        m_s2[i] = m_s1[i];
        m_s1[i] = e;
      end
      if (wr_en && run && wr_sel < 3) m_reg[wr_sel] = wr_data;
      case (m_st)
        0: if (!m_pd2) m_st = 1;
        1: if (quiet) m_st = 2;
        2: if (m_pd2) begin m_st = 3; m_cnt = 0; end
        default: begin
          if (!m_pd2) m_st = 1;
          else if (m_cnt == LOCK - 1) m_st = 0;
          else m_cnt = m_cnt + 1;
        end
      endcase
      m_pd2 = m_pd1;
      m_pd1 = pd_n;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison and pulse-width monitor
  int runlen [NO];
  initial for (int i = 0; i < NO; i++) runlen[i] = 0;
  always @(negedge clk) if (rst_n && !finished) begin
    logic [NO-1:0] exp_o;
    for (int i = 0; i < NO; i++) exp_o[i] = m_o[i];
    check(clk_out == exp_o, "R4 clk_out cycle timing", int'(clk_out), int'(exp_o));
    check(pll_off_req == (m_st == 2), "R5 pll_off_req", pll_off_req, m_st == 2);
    check(ser_en == (m_st == 0), "R6 ser_en", ser_en, m_st == 0);
    for (int i = 0; i < NO; i++) begin
      if (clk_out[i]) runlen[i]++;
      else if (runlen[i] > 0) begin
        check(runlen[i] == half[i], "R3 pulse width", runlen[i], half[i]);
        runlen[i] = 0;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int sel, input int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int sel, output int val);
    @(negedge clk);
    rd_sel = 2'(sel);
    #1 val = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // outputs in mask that went high during n cycles
  task automatic watch(input int n, input logic [NO-1:0] mask, output logic [NO-1:0] seen);
    seen = '0;
    repeat (n) begin
      @(negedge clk);
      #1 seen = seen | (clk_out & mask);
    end
  endtask

  initial begin
    int v;
    logic [NO-1:0] seen;
    int zeros;

    idle(3);
    check(clk_out == '0, "R1 outputs low in reset", int'(clk_out), 0);
    @(negedge clk) rst_n = 1;
    rd(0, v); check(v == 'h07, "R1 host default", v, 'h07);
    rd(1, v); check(v == 'hFF, "R1 memory default", v, 'hFF);
    rd(2, v); check(v == 'hFE, "R1 periph default", v, 'hFE);
    rd(3, v); check(v == 0, "R10 unmapped read", v, 0);

    watch(40, '1, seen);
    check(seen[10:0] == 11'h7FF, "R2 default-enabled outputs toggle", int'(seen), 'h7FF);
    check(seen[11] == 1'b1, "R2 periph output toggles", seen[11], 1);

    wr(1, 'h5A);
    wr(3, 'h00);
    rd(1, v); check(v == 'h5A, "R10 unmapped write ignored", v, 'h5A);
    idle(10);
    watch(50, 18'(8'hA5) << 3, seen);
    check(seen == '0, "R2 memory bits cleared stay low", int'(seen), 0);
    watch(30, 18'(8'h5A) << 3, seen);
    check(seen == (18'(8'h5A) << 3), "R2 memory bits set run", int'(seen), int'(18'(8'h5A) << 3));

    wr(0, 'hF8);
    rd(0, v); check(v == 'hF8, "R8 host reserved readback", v, 'hF8);
    wr(2, 'h01);
    rd(2, v); check(v == 'h01, "R8 periph reserved readback", v, 'h01);
    idle(10);
    watch(40, 18'h3F807, seen);
    check(seen == '0, "R8 reserved bits gate nothing", int'(seen), 0);

    wr(0, 'h0F); wr(2, 'hFF);
    for (int k = 0; k < 30; k++) begin
      wr(1, (k % 2) ? 'hFF : 'h00);
      idle(k % 4);
    end
    wr(1, 'hC3);

    // power-down with a write in the same cycle
    @(negedge clk);
    pd_n = 0; wr_en = 1; wr_sel = 2'd1; wr_data = 8'h3C;
    @(negedge clk); wr_en = 0;
    v = 0;
    for (int k = 0; k < 200 && !pll_off_req; k++) begin @(negedge clk); v++; end
    check(pll_off_req == 1'b1, "R5 shutdown request reached", pll_off_req, 1);
    check(clk_out == '0, "R5 outputs parked", int'(clk_out), 0);
    check(ser_en == 1'b0, "R6 serial disabled in shutdown", ser_en, 0);
    rd(1, v); check(v == 0, "R6 reads zero when disabled", v, 0);
    wr(1, 'h00);
    idle(20);

    pd_n = 1;
    while (pll_off_req) @(negedge clk);
    zeros = 0;
    while (clk_out == '0 && zeros < 400) begin @(negedge clk); #1; zeros++; end
    check(zeros >= LOCK, "R7 outputs held during lock wait", zeros, LOCK);
    rd(1, v); check(v == 'h3C, "R9 memory kept through power-down", v, 'h3C);
    rd(0, v); check(v == 'h0F, "R9 host kept through power-down", v, 'h0F);

    // power-down again, then abort lock wait
    @(negedge clk) pd_n = 0;
    while (!pll_off_req) @(negedge clk);
    idle(5);
    pd_n = 1;
    while (pll_off_req) @(negedge clk);
    idle(10);
    pd_n = 0;
    v = 0;
    for (int k = 0; k < 40 && !pll_off_req; k++) begin @(negedge clk); v++; end
    check(pll_off_req == 1'b1, "R7 low pd_n in lock wait returns to shutdown", pll_off_req, 1);
    pd_n = 1;
    idle(LOCK + 60);
    rd(2, v); check(v == 'hFF, "R9 periph kept", v, 'hFF);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule